// File: doc/BRIEF.md
# Calendar Alarm Match Comparator

This block watches a running clock/calendar and decides when either of two alarms has been reached. Each alarm keeps six bytes: seconds, minutes, hours, date, month and day of week. Each byte has the same layout as the matching time byte, except that its top bit is an enable. Only enabled fields take part in the comparison. An alarm with no enabled field stays silent. The time fields arrive as BCD values. A one-cycle seconds strobe tells the block when a new second has begun, so each match is found once per second and not on every clock cycle.

A match sets a sticky status flag for that alarm, which software polls and clears with a per-alarm clear input. Each alarm also has a mode bit. In single-event mode the alarm fires once and then goes quiet until software writes any of its registers again. In periodic mode it fires on every match, and each match also sends a one-clock pulse on that alarm's interrupt output. Each alarm is run by a two-state machine. ARMED goes to SPENT on a single-event match (transition FIRE_ONCE). SPENT goes back to ARMED on a register write to that alarm (transition REARM). A write in the same cycle as a match keeps the machine in ARMED.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset both flags and both interrupt outputs are 0, every alarm byte and mode bit is 0, and both machines are ARMED. So no alarm fires until it is configured.
- R2: Alarm register addresses are 0 seconds, 1 minutes, 2 hours, 3 date, 4 month and 5 day of week. In each byte, bit 7 = 1 enables the field, and bits 6:0 are compared with the 7-bit time byte. The 3-bit day-of-week input (0 to 6) is zero-extended to 7 bits before the comparison. A field with bit 7 = 0 does not affect the match.
- R3: A match is evaluated only in a cycle where `tick` is 1. The flag is set on the following clock edge. Matching fields without `tick` set nothing.
- R4: An alarm whose six enable bits are all 0 never sets its flag or pulses its interrupt.
- R5: A flag stays 1 until its `flag_clr` bit is 1 in a cycle without a new match. When a clear and a match arrive together, the flag stays 1.
- R6: Address 6 is the mode register, and bit 0 is the mode: 0 means single-event, 1 means periodic. In single-event mode the first match moves the alarm to SPENT. Later matches are then ignored until a write to one of its addresses 0 to 6. The interrupt output stays 0 in single-event mode.
- R7: In periodic mode every match sets the flag and drives that alarm's interrupt output to 1 for exactly the one cycle after the tick.
- R8: `wr_sel` picks the alarm that a write reaches (0 or 1). The two alarms' registers, flags, modes and machines are independent.
- R9: A write to address 7 changes no register and does not rearm a SPENT alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| tick | input | 1 | one-cycle seconds strobe |
| tm_sec | input | 7 | BCD seconds |
| tm_min | input | 7 | BCD minutes |
| tm_hour | input | 7 | BCD hours |
| tm_date | input | 7 | BCD date |
| tm_month | input | 7 | BCD month |
| tm_dow | input | 3 | day of week, 0 to 6 |
| wr_en | input | 1 | register write strobe |
| wr_sel | input | 1 | alarm selected by the write |
| wr_addr | input | 3 | field address 0-5, mode 6 |
| wr_data | input | 8 | write data |
| flag_clr | input | 2 | per-alarm flag clear |
| alarm_flag | output | 2 | sticky match flags |
| alarm_irq | output | 2 | periodic match pulses |

## Verification
The bench checks a single-event alarm that is matched a second time while SPENT. A design that forgot the SPENT state would raise the flag again. It also checks that a write to address 7 does not rearm that SPENT alarm. A clear in the same cycle as a match has to leave the flag set, and a wrong priority would drop the event. Matching fields without `tick`, and alarms with every enable cleared, must stay silent. A day-of-week enable is compared against the zero-extended 3-bit input. Long random runs use small time values so that matches, clears, mode changes and rearms all collide often.

// File: rtl/alm_pkg.sv
package alm_pkg;
    localparam int N_FIELDS = 6;
    localparam int FIELD_W  = 7;
    localparam int BYTE_W   = 8;
    localparam int DOW_W    = 3;
    localparam int ADDR_W   = 3;
    localparam int EN_BIT   = BYTE_W - 1;
    localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd6;

    typedef enum logic [0:0] {
        ST_ARMED = 1'b0,
        ST_SPENT = 1'b1
    } alm_state_e;
endpackage

// File: rtl/alm_regs.sv
module alm_regs
    import alm_pkg::*;
#(
    parameter int N_ALARMS = 2,
    parameter int SEL_W    = 1
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       wr_en,
    input  logic [SEL_W-1:0]                           wr_sel,
    input  logic [ADDR_W-1:0]                          wr_addr,
    input  logic [BYTE_W-1:0]                          wr_data,
    output logic [N_ALARMS-1:0][N_FIELDS-1:0][BYTE_W-1:0] alm_bytes,
    output logic [N_ALARMS-1:0]                        periodic,
    output logic [N_ALARMS-1:0]                        rearm
);
    for (genvar a = 0; a < N_ALARMS; a++) begin : g_alarm
        logic sel_me;
        logic mode_q;

        assign sel_me   = wr_en && (wr_sel == SEL_W'(a));
        assign rearm[a] = sel_me && (wr_addr <= ADDR_MODE);

        always_ff @(posedge clk) begin
            if (!rst_n)
                mode_q <= 1'b0;
            else if (sel_me && wr_addr == ADDR_MODE)
                mode_q <= wr_data[0];
        end
        assign periodic[a] = mode_q;

        for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
            logic [BYTE_W-1:0] byte_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    byte_q <= '0;
                else if (sel_me && wr_addr == ADDR_W'(f))
                    byte_q <= wr_data;
            end
            assign alm_bytes[a][f] = byte_q;
        end

        // R9: the unused address never counts as a register write
        assert_addr7_no_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_addr == 3'd7) |-> !rearm[a]);
    end
endmodule

// File: rtl/alm_compare.sv
module alm_compare
    import alm_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               tick,
    input  logic [N_FIELDS-1:0][BYTE_W-1:0]    alm_bytes,
    input  logic [N_FIELDS-1:0][FIELD_W-1:0]   now,
    output logic                               hit
);
    logic [N_FIELDS-1:0] en;
    logic [N_FIELDS-1:0] agree;

    for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
        assign en[f]    = alm_bytes[f][EN_BIT];
        assign agree[f] = !en[f] || (alm_bytes[f][FIELD_W-1:0] == now[f]);
    end

    assign hit = tick && (|en) && (&agree);

    assert_hit_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> tick);
    assert_no_enable_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !hit);
endmodule

// File: rtl/alm_ctrl.sv
module alm_ctrl
    import alm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic periodic,
    input  logic rearm,
    input  logic clr,
    output logic flag,
    output logic irq
);
    alm_state_e state_q, state_d;
    logic       fire;

    assign fire = hit && (state_q == ST_ARMED);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: if (hit && !periodic && !rearm) state_d = ST_SPENT;
            ST_SPENT: if (rearm)                      state_d = ST_ARMED;
            default:                                  state_d = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
            irq  <= 1'b0;
        end else begin
            if (fire)     flag <= 1'b1;
            else if (clr) flag <= 1'b0;
            irq <= fire && periodic;
        end
    end

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    assert_flag_rise_after_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(hit));
    assert_single_no_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !periodic |=> !irq);
    assert_spent_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPENT && !rearm) |=> !$rose(flag));
    assert_irq_with_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
    import alm_pkg::*;
#(
    parameter int N_ALARMS = 2,
    localparam int SEL_W   = (N_ALARMS > 1) ? $clog2(N_ALARMS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [FIELD_W-1:0]  tm_sec,
    input  logic [FIELD_W-1:0]  tm_min,
    input  logic [FIELD_W-1:0]  tm_hour,
    input  logic [FIELD_W-1:0]  tm_date,
    input  logic [FIELD_W-1:0]  tm_month,
    input  logic [DOW_W-1:0]    tm_dow,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic [N_ALARMS-1:0] flag_clr,
    output logic [N_ALARMS-1:0] alarm_flag,
    output logic [N_ALARMS-1:0] alarm_irq
);
    logic [N_FIELDS-1:0][FIELD_W-1:0]             now;
    logic [N_ALARMS-1:0][N_FIELDS-1:0][BYTE_W-1:0] alm_bytes;
    logic [N_ALARMS-1:0]                          periodic;
    logic [N_ALARMS-1:0]                          rearm;
    logic [N_ALARMS-1:0]                          hit;

    // R2: field order is the register address order
    assign now[0] = tm_sec;
    assign now[1] = tm_min;
    assign now[2] = tm_hour;
    assign now[3] = tm_date;
    assign now[4] = tm_month;
    assign now[5] = {{(FIELD_W-DOW_W){1'b0}}, tm_dow};

    alm_regs #(.N_ALARMS(N_ALARMS), .SEL_W(SEL_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .alm_bytes (alm_bytes),
        .periodic  (periodic),
        .rearm     (rearm)
    );

    for (genvar a = 0; a < N_ALARMS; a++) begin : g_alarm
        alm_compare i_cmp (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .alm_bytes (alm_bytes[a]),
            .now       (now),
            .hit       (hit[a])
        );

        alm_ctrl i_ctrl (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit      (hit[a]),
            .periodic (periodic[a]),
            .rearm    (rearm[a]),
            .clr      (flag_clr[a]),
            .flag     (alarm_flag[a]),
            .irq      (alarm_irq[a])
        );
    end

    // R8: each flag only rises through its own alarm's match
    assert_flag_own_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit[0]) |=> !$rose(alarm_flag[0]));
endmodule

// File: tb/test_alarm_match_unit.sv
module test_alarm_match_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick;
    logic [6:0] tm_sec, tm_min, tm_hour, tm_date, tm_month;
    logic [2:0] tm_dow;
    logic       wr_en;
    logic       wr_sel;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;
    logic [1:0] flag_clr;
    logic [1:0] alarm_flag;
    logic [1:0] alarm_irq;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    // bench model state
    logic [7:0] m_byte [2][6];
    logic       m_mode [2];
    logic       m_spent[2];
    logic [1:0] m_flag;
    logic [1:0] m_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    alarm_match_unit i_alarm_match_unit (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour),
        .tm_date(tm_date), .tm_month(tm_month), .tm_dow(tm_dow),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
        .flag_clr(flag_clr), .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
    );

    function automatic logic [6:0] time_field(int f);
        case (f)
            0: return tm_sec;
            1: return tm_min;
            2: return tm_hour;
            3: return tm_date;
            4: return tm_month;
            default: return {4'b0, tm_dow};
        endcase
    endfunction

    function automatic logic model_match(int a);
        logic any_en = 1'b0;
        logic ok     = 1'b1;
        for (int f = 0; f < 6; f++) begin
            if (m_byte[a][f][7]) begin
                any_en = 1'b1;
                if (m_byte[a][f][6:0] != time_field(f)) ok = 1'b0;
            end
        end
        return tick && any_en && ok;
    endfunction

    task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic set_time(logic [6:0] s, logic [6:0] mi, logic [6:0] h,
                            logic [6:0] d, logic [6:0] mo, logic [2:0] w);
        tm_sec = s; tm_min = mi; tm_hour = h; tm_date = d; tm_month = mo; tm_dow = w;
    endtask

    // drive one cycle, advance the model, then compare at the next falling edge
    task automatic cyc(logic tk, logic we, logic ws, logic [2:0] wa,
                       logic [7:0] wd, logic [1:0] cl, string tag);
        logic fire[2];
        tick = tk; wr_en = we; wr_sel = ws; wr_addr = wa; wr_data = wd; flag_clr = cl;
        for (int a = 0; a < 2; a++) fire[a] = model_match(a) && !m_spent[a];
        for (int a = 0; a < 2; a++) begin
            logic rearm;
            rearm = we && (ws == a[0]) && (wa <= 3'd6);
            if (fire[a])      m_flag[a] = 1'b1;
            else if (cl[a])   m_flag[a] = 1'b0;
            m_irq[a] = fire[a] && m_mode[a];
            if (rearm)                     m_spent[a] = 1'b0;
            else if (fire[a] && !m_mode[a]) m_spent[a] = 1'b1;
            if (we && (ws == a[0])) begin
                if (wa < 3'd6)       m_byte[a][wa] = wd;
                else if (wa == 3'd6) m_mode[a]     = wd[0];
            end
        end
        @(negedge clk);
        chk({tag, " flag"}, alarm_flag, m_flag);
        chk({tag, " irq"},  alarm_irq,  m_irq);
    endtask

    task automatic wr(logic ws, logic [2:0] wa, logic [7:0] wd, string tag);
        cyc(1'b0, 1'b1, ws, wa, wd, 2'b00, tag);
    endtask

    task automatic tk(string tag);
        cyc(1'b1, 1'b0, 1'b0, 3'd0, 8'd0, 2'b00, tag);
    endtask

    task automatic clr(logic [1:0] c, string tag);
        cyc(1'b0, 1'b0, 1'b0, 3'd0, 8'd0, c, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24680));
        for (int a = 0; a < 2; a++) begin
            for (int f = 0; f < 6; f++) m_byte[a][f] = 8'h00;
            m_mode[a] = 1'b0; m_spent[a] = 1'b0;
        end
        m_flag = 2'b00; m_irq = 2'b00;
        rst_n = 1'b0; tick = 0; wr_en = 0; wr_sel = 0; wr_addr = 0; wr_data = 0; flag_clr = 0;
        set_time(7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 3'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset flag", alarm_flag, 2'b00);
        chk("R1 reset irq",  alarm_irq,  2'b00);
        tk("R1 unconfigured tick");
        tk("R4 no enable");
        chk("R4 no enable const", alarm_flag, 2'b00);

        // R2: seconds field, enable in bit 7
        wr(1'b0, 3'd0, 8'hA5, "R2 write sec");
        set_time(7'h24, 7'h10, 7'h08, 7'h01, 7'h01, 3'd2);
        tk("R2 sec mismatch");
        chk("R2 mismatch const", alarm_flag, 2'b00);
        // R3: matching value without the tick
        set_time(7'h25, 7'h10, 7'h08, 7'h01, 7'h01, 3'd2);
        cyc(1'b0, 1'b0, 1'b0, 3'd0, 8'd0, 2'b00, "R3 no tick");
        chk("R3 no tick const", alarm_flag, 2'b00);
        tk("R2 sec match");
        chk("R2 sec match const", alarm_flag, 2'b01);
        // R6: a single-event alarm is spent after one match
        clr(2'b01, "R5 clear");
        chk("R5 clear const", alarm_flag, 2'b00);
        tk("R6 spent ignores match");
        chk("R6 spent const", alarm_flag, 2'b00);
        // R9: address 7 does not rearm
        wr(1'b0, 3'd7, 8'hFF, "R9 addr7 write");
        tk("R9 still spent");
        chk("R9 still spent const", alarm_flag, 2'b00);
        // R2: day of week, zero-extended
        wr(1'b0, 3'd5, 8'h82, "R2 write dow");
        tk("R2 dow match");
        chk("R2 dow match const", alarm_flag, 2'b01);
        set_time(7'h25, 7'h10, 7'h08, 7'h01, 7'h01, 3'd6);
        wr(1'b0, 3'd5, 8'h86, "R2 dow six");
        tk("R2 dow six match");
        // R5: clear and match together keep the flag
        wr(1'b0, 3'd6, 8'h01, "R7 set periodic");
        cyc(1'b1, 1'b0, 1'b0, 3'd0, 8'd0, 2'b01, "R5 clear with match");
        chk("R5 clear with match const", alarm_flag, 2'b01);
        chk("R7 periodic pulse const", alarm_irq, 2'b01);
        clr(2'b00, "R7 pulse one cycle");
        chk("R7 pulse ends const", alarm_irq, 2'b00);
        tk("R7 periodic again");
        chk("R7 periodic again const", alarm_irq, 2'b01);
        // R8: alarm 1 on minutes only, alarm 0 disabled
        for (int f = 0; f < 6; f++) wr(1'b0, f[2:0], 8'h00, "R8 clear alarm0");
        clr(2'b11, "R8 clear flags");
        wr(1'b1, 3'd1, 8'h90, "R8 write alarm1 min");
        tk("R8 alarm1 only");
        chk("R8 alarm1 only const", alarm_flag, 2'b10);
        chk("R8 single no irq const", alarm_irq, 2'b00);
        tk("R6 alarm1 spent");
        wr(1'b1, 3'd4, 8'h00, "R6 rearm by write");
        tk("R6 rearmed match");

        // random phase: small value ranges so matches collide with everything
        for (int i = 0; i < 6000; i++) begin
            logic [2:0] wa;
            logic [7:0] wd;
            set_time(7'($urandom_range(0, 2)), 7'($urandom_range(0, 1)), 7'd0,
                     7'($urandom_range(0, 1)), 7'd1, 3'($urandom_range(0, 6)));
            wa = 3'($urandom_range(0, 7));
            wd = {1'($urandom % 3 == 0), 7'($urandom_range(0, 2))};
            if (wa == 3'd1 || wa == 3'd3) wd[6:0] = 7'($urandom_range(0, 1));
            if (wa == 3'd2) wd[6:0] = 7'd0;
            if (wa == 3'd4) wd[6:0] = 7'd1;
            if (wa == 3'd6) wd[0]   = 1'($urandom);
            cyc(1'($urandom), ($urandom % 5 == 0), 1'($urandom), wa, wd,
                2'(($urandom % 6 == 0) ? $urandom : 0), "R8 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule